// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Write Modes

This block is a synchronous memory with two fully independent access ports. Each port has an enable, byte-lane write enables, an address, write data and a read output. The ports share one clock. Every access is sampled on a rising edge. The read output of a port is a register. It changes only when that port performs an access, so it keeps its value across idle cycles.

Each port has its own write-mode parameter. The mode decides what the port's output shows after that port writes:
- the freshly written data,
- the word as it was before the write, or
- the previous output, left unchanged.

An optional pipeline register per port delays the output by exactly one more cycle. A registered collision flag marks cycles in which both ports touched one address while at least one of them was writing. The read data of such a cycle is not defined.

Top module: `dpram_wmode`

## Requirements
- R1: With the port's pipeline stage off, an enabled read presents the stored word on that port's output right after the clock edge that samples it. An enabled write stores its data at that same edge.
- R2: While a port's enable is low, that port writes nothing, whatever its write enables say, and its output keeps its value.
- R3: In write-first mode (mode code 0, the default), a write makes the output show the new data on the written byte lanes and the old stored bytes on the unwritten lanes.
- R4: In read-first mode (mode code 1), a write makes the output show the word stored at that address before the write.
- R5: In no-change mode (mode code 2), a write leaves the output unchanged while still updating the memory.
- R6: For 16- and 32-bit data widths, write-enable bit i controls data bits [8i+7:8i]. For any other width the port has a single write-enable bit covering the whole word.
- R7: With a port's pipeline parameter set, that port's output arrives exactly one cycle later than with the parameter clear.
- R8: The collision output is high in the cycle after an edge at which both ports were enabled on equal addresses with at least one port writing. It is low after any other edge.
- R9: Both ports may read the same address at one edge. Both get the stored word, and no collision is flagged.
- R10: A synchronous active-high reset clears both outputs and the collision flag. It does not clear the memory contents.
- R11: Two writes from the two ports to different addresses at one edge are both stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| en_a | input | 1 | Port A access enable |
| we_a | input | LANES | Port A byte-lane write enables |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | DATA_W | Port A write data |
| rdata_a | output | DATA_W | Port A read output |
| en_b | input | 1 | Port B access enable |
| we_b | input | LANES | Port B byte-lane write enables |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | DATA_W | Port B write data |
| rdata_b | output | DATA_W | Port B read output |
| collision | output | 1 | Same-address conflict seen at the previous edge |

## Verification
The hardest state to reach is a partial-lane write in write-first mode. There, the output must merge new and old bytes, so the address has to hold a known, distinct pattern in every lane first. The stimulus table first fills two words with full writes. It then writes single lanes into them and reads them back through the other lanes.

The no-change port with its pipeline stage enabled is also awkward to check. Its output must stay frozen across a write and then move two edges after a read. The bench drives a second instance and samples both the first and the second cycle after each access.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  // byte-lane count: per-byte enables only for 16 and 32 bit words
  function automatic int lanes_for(int width);
    return (width == 16 || width == 32) ? width / 8 : 1;
  endfunction

endpackage

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter dpr_pkg::wmode_e MODE_A = dpr_pkg::WM_WRITE_FIRST,
  parameter dpr_pkg::wmode_e MODE_B = dpr_pkg::WM_WRITE_FIRST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a,
  input  logic [LANES-1:0]  we_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  input  logic              en_b,
  input  logic [LANES-1:0]  we_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];

  // lane-wise merge of new data over the stored word
  function automatic logic [DATA_W-1:0] merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [LANES-1:0]  lane_en
  );
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int l = 0; l < LANES; l++)
      if (lane_en[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  // value the output latch takes on an enabled access
  function automatic logic [DATA_W-1:0] next_q(
    input dpr_pkg::wmode_e    mode,
    input logic [DATA_W-1:0]  old_w,
    input logic [DATA_W-1:0]  new_w,
    input logic [LANES-1:0]   lane_en,
    input logic [DATA_W-1:0]  cur
  );
    logic [DATA_W-1:0] r;
    case (mode)
      dpr_pkg::WM_READ_FIRST: r = old_w;
      dpr_pkg::WM_NO_CHANGE:  r = (|lane_en) ? cur : old_w;
      default:                r = merge(old_w, new_w, lane_en);
    endcase
    return r;
  endfunction

  // single writer process: both ports, lane by lane
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (en_a && we_a[l]) mem[addr_a][l*LANE_W +: LANE_W] <= wdata_a[l*LANE_W +: LANE_W];
      if (en_b && we_b[l]) mem[addr_b][l*LANE_W +: LANE_W] <= wdata_b[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       q_a <= '0;
    else if (en_a) q_a <= next_q(MODE_A, mem[addr_a], wdata_a, we_a, q_a);
  end

  always_ff @(posedge clk) begin
    if (rst)       q_b <= '0;
    else if (en_b) q_b <= next_q(MODE_B, mem[addr_b], wdata_b, we_b, q_b);
  end

endmodule

// File: rtl/dpr_pipe.sv
module dpr_pipe #(
  parameter int DATA_W = 32,
  parameter bit ENABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  generate
    if (ENABLE) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= din;
      end
    end else begin : g_wire
      assign dout = din;
    end
  endgenerate

endmodule

// File: rtl/dpr_collide.sv
module dpr_collide #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              en_b,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              flag
);

  logic hit;
  assign hit = en_a && en_b && (addr_a == addr_b) && (wr_a || wr_b);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= hit;
  end

endmodule

// File: rtl/dpram_wmode.sv
module dpram_wmode #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter dpr_pkg::wmode_e MODE_A = dpr_pkg::WM_WRITE_FIRST,
  parameter dpr_pkg::wmode_e MODE_B = dpr_pkg::WM_WRITE_FIRST,
  parameter bit PIPE_A = 1'b0,
  parameter bit PIPE_B = 1'b0,
  localparam int LANES = dpr_pkg::lanes_for(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a,
  input  logic [LANES-1:0]  we_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic              en_b,
  input  logic [LANES-1:0]  we_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] rdata_b,
  output logic              collision
);

  logic [DATA_W-1:0] q_a, q_b;

  dpr_array #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES),
    .MODE_A(MODE_A), .MODE_B(MODE_B)
  ) u_array (
    .clk(clk), .rst(rst),
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wdata_a),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wdata_b),
    .q_a(q_a), .q_b(q_b)
  );

  dpr_pipe #(.DATA_W(DATA_W), .ENABLE(PIPE_A)) u_pipe_a (
    .clk(clk), .rst(rst), .din(q_a), .dout(rdata_a)
  );

  dpr_pipe #(.DATA_W(DATA_W), .ENABLE(PIPE_B)) u_pipe_b (
    .clk(clk), .rst(rst), .din(q_b), .dout(rdata_b)
  );

  dpr_collide #(.ADDR_W(ADDR_W)) u_collide (
    .clk(clk), .rst(rst),
    .en_a(en_a), .wr_a(|we_a), .addr_a(addr_a),
    .en_b(en_b), .wr_b(|we_b), .addr_b(addr_b),
    .flag(collision)
  );

endmodule

// File: rtl/dpram_wmode_chk.sv
module dpram_wmode_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter dpr_pkg::wmode_e MODE_A = dpr_pkg::WM_WRITE_FIRST,
  parameter dpr_pkg::wmode_e MODE_B = dpr_pkg::WM_WRITE_FIRST,
  parameter bit PIPE_A = 1'b0,
  parameter bit PIPE_B = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              en_a,
  input logic [LANES-1:0]  we_a,
  input logic [ADDR_W-1:0] addr_a,
  input logic [DATA_W-1:0] wdata_a,
  input logic [DATA_W-1:0] rdata_a,
  input logic              en_b,
  input logic [LANES-1:0]  we_b,
  input logic [ADDR_W-1:0] addr_b,
  input logic [DATA_W-1:0] rdata_b,
  input logic              collision
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rdata_a == '0 && rdata_b == '0 && !collision)); // R10

  AST_COLLISION_SET: assert property (@(posedge clk) disable iff (rst)
    (en_a && en_b && addr_a == addr_b && ((|we_a) || (|we_b))) |=> collision); // R8

  AST_COLLISION_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(en_a && en_b) |=> !collision); // R8

  generate
    if (!PIPE_A) begin : g_a_direct
      AST_IDLE_HOLD_A: assert property (@(posedge clk) disable iff (rst)
        !en_a |=> $stable(rdata_a)); // R2
      if (MODE_A == dpr_pkg::WM_WRITE_FIRST) begin : g_wf
        AST_WRITE_FIRST_A: assert property (@(posedge clk) disable iff (rst)
          (en_a && (&we_a)) |=> (rdata_a == $past(wdata_a))); // R3
      end
      if (MODE_A == dpr_pkg::WM_NO_CHANGE) begin : g_nc
        AST_NO_CHANGE_A: assert property (@(posedge clk) disable iff (rst)
          (en_a && (|we_a)) |=> $stable(rdata_a)); // R5
      end
    end
    if (!PIPE_B) begin : g_b_direct
      AST_IDLE_HOLD_B: assert property (@(posedge clk) disable iff (rst)
        !en_b |=> $stable(rdata_b)); // R2
      if (MODE_B == dpr_pkg::WM_NO_CHANGE) begin : g_nc
        AST_NO_CHANGE_B: assert property (@(posedge clk) disable iff (rst)
          (en_b && (|we_b)) |=> $stable(rdata_b)); // R5
      end
    end
  endgenerate

endmodule

bind dpram_wmode dpram_wmode_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES),
  .MODE_A(MODE_A), .MODE_B(MODE_B), .PIPE_A(PIPE_A), .PIPE_B(PIPE_B)
) u_chk (
  .clk(clk), .rst(rst),
  .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a),
  .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .rdata_b(rdata_b),
  .collision(collision)
);

// File: tb/dpram_wmode_test.sv
module dpram_wmode_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  // main instance: A write-first, B read-first, no pipeline
  logic        en_a = 0, en_b = 0;
  logic [3:0]  we_a = 0, we_b = 0;
  logic [5:0]  addr_a = 0, addr_b = 0;
  logic [31:0] wd_a = 0, wd_b = 0;
  logic [31:0] rd_a, rd_b;
  logic        coll;

  // second instance: A no-change with pipeline
  logic        en2 = 0;
  logic [3:0]  we2 = 0;
  logic [5:0]  addr2 = 0;
  logic [31:0] wd2 = 0;
  logic [31:0] rd2, rd2_b;
  logic        coll2;

  dpram_wmode #(.MODE_A(dpr_pkg::WM_WRITE_FIRST), .MODE_B(dpr_pkg::WM_READ_FIRST)) uut (
    .clk(clk), .rst(rst),
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .wdata_a(wd_a), .rdata_a(rd_a),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .wdata_b(wd_b), .rdata_b(rd_b),
    .collision(coll)
  );

  dpram_wmode #(.MODE_A(dpr_pkg::WM_NO_CHANGE), .PIPE_A(1'b1)) uut2 (
    .clk(clk), .rst(rst),
    .en_a(en2), .we_a(we2), .addr_a(addr2), .wdata_a(wd2), .rdata_a(rd2),
    .en_b(1'b0), .we_b(4'h0), .addr_b(6'd0), .wdata_b(32'h0), .rdata_b(rd2_b),
    .collision(coll2)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {en, we[3:0], addr[5:0], wdata[31:0], expected rdata_a[31:0]}
  localparam logic [74:0] VEC [8] = '{
    {1'b1, 4'hF, 6'd1, 32'h11111111, 32'h11111111},
    {1'b1, 4'hF, 6'd2, 32'h22222222, 32'h22222222},
    {1'b1, 4'h0, 6'd1, 32'h00000000, 32'h11111111},
    {1'b1, 4'h3, 6'd1, 32'hAAAABBBB, 32'h1111BBBB},
    {1'b0, 4'hF, 6'd2, 32'hDEADBEEF, 32'h1111BBBB},
    {1'b1, 4'h0, 6'd2, 32'h00000000, 32'h22222222},
    {1'b1, 4'h8, 6'd2, 32'hCC000000, 32'hCC222222},
    {1'b1, 4'h0, 6'd1, 32'h00000000, 32'h1111BBBB}
  };

  task automatic idle_all();
    en_a = 0; we_a = 0; en_b = 0; we_b = 0; en2 = 0; we2 = 0;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset rdata_a", rd_a, 32'h0);
    check("R10 reset rdata_b", rd_b, 32'h0);
    check("R10 reset collision", {31'h0, coll}, 32'h0);
    rst = 0;

    // R1 R2 R3 R6: table on port A
    for (int i = 0; i < 8; i++) begin
      {en_a, we_a, addr_a, wd_a} = VEC[i][74:32];
      @(negedge clk);
      check($sformatf("R1/R2/R3/R6 vector %0d", i), rd_a, VEC[i][31:0]);
    end
    idle_all();

    // R4: read-first on port B returns old contents
    en_b = 1; we_b = 4'hF; addr_b = 6'd1; wd_b = 32'h55555555;
    @(negedge clk);
    check("R4 read-first old word", rd_b, 32'h1111BBBB);
    check("R8 no collision single port", {31'h0, coll}, 32'h0);
    idle_all();

    // R9: both ports read the same address
    en_a = 1; addr_a = 6'd1; en_b = 1; addr_b = 6'd1;
    @(negedge clk);
    check("R9 dual read A", rd_a, 32'h55555555);
    check("R9 dual read B", rd_b, 32'h55555555);
    check("R9 no collision", {31'h0, coll}, 32'h0);

    // R11: both ports write different addresses
    en_a = 1; we_a = 4'hF; addr_a = 6'd3; wd_a = 32'h33333333;
    en_b = 1; we_b = 4'hF; addr_b = 6'd4; wd_b = 32'h44444444;
    @(negedge clk);
    check("R3 full write-first", rd_a, 32'h33333333);
    check("R11 no collision distinct", {31'h0, coll}, 32'h0);
    we_a = 0; we_b = 0; addr_a = 6'd4; addr_b = 6'd3;
    @(negedge clk);
    check("R11 A sees B write", rd_a, 32'h44444444);
    check("R11 B sees A write", rd_b, 32'h33333333);

    // R8: write on A, read on B, same address
    we_a = 4'h1; addr_a = 6'd3; wd_a = 32'h000000EE; we_b = 0; addr_b = 6'd3;
    @(negedge clk);
    check("R8 collision raised", {31'h0, coll}, 32'h1);
    idle_all();
    @(negedge clk);
    check("R8 collision cleared", {31'h0, coll}, 32'h0);

    // R10: reset clears outputs, keeps memory
    en_a = 1; addr_a = 6'd2;
    @(negedge clk);
    idle_all(); rst = 1;
    @(negedge clk);
    check("R10 mid reset rdata_a", rd_a, 32'h0);
    rst = 0; en_a = 1; addr_a = 6'd2;
    @(negedge clk);
    check("R10 memory kept", rd_a, 32'hCC222222);
    idle_all();

    // R5 R7: no-change port with pipeline stage
    en2 = 1; we2 = 4'hF; addr2 = 6'd5; wd2 = 32'h12345678;
    @(negedge clk);
    idle_all();
    @(negedge clk);
    check("R5 no-change after write", rd2, 32'h0);
    en2 = 1; addr2 = 6'd5;
    @(negedge clk);
    idle_all();
    check("R7 not yet at first cycle", rd2, 32'h0);
    @(negedge clk);
    check("R7 arrives one cycle later", rd2, 32'h12345678);
    en2 = 1; we2 = 4'hF; addr2 = 6'd5; wd2 = 32'h00009999;
    @(negedge clk);
    idle_all();
    @(negedge clk);
    check("R5 output frozen on write", rd2, 32'h12345678);
    en2 = 1; addr2 = 6'd5;
    @(negedge clk);
    idle_all();
    @(negedge clk);
    check("R5 memory updated", rd2, 32'h00009999);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule